// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Band Insertion

This block drives the two switches of a half-bridge power stage. A free-running timer counts from zero up to a programmable period value and then wraps. While the count is below the duty value the underlying PWM signal is high. Output A follows that signal, and output B follows its complement. Both outputs are active-high.

To keep the upper and lower switches from conducting at the same time, a programmable dead-band delay postpones every inactive-to-active edge. An output may only go active once the underlying signal has held its new level for the programmed number of clock cycles. Falling edges are never delayed. If an output's active window is no longer than the delay, that output stays low for the whole window.

The period, duty and dead-band inputs behave like registers that software writes at any time. The block samples them only at a period boundary, or continuously while it is disabled, so a write never cuts a pulse short in mid-cycle. A per-output enable mask can force either output low without disturbing the timing.

Top module: `cpwm_deadband`

## Requirements
- R1: While enabled, the timer steps by one each clock and returns to zero in the cycle after it equals the period value P, so a period lasts P+1 cycles. The underlying PWM signal is high exactly when the timer is below the duty value D.
- R2: Output B's window is the complement of the underlying signal: it covers the timer counts from D to P.
- R3: Each output rises only after the underlying signal has held its new level for dead-band value T cycles (T from 0 to 127). Its falling edge follows the underlying signal in the same cycle. For P=9, D=4, T=2, A is high 2 cycles and B 4 cycles per period.
- R4: If T is greater than or equal to the length of an output's window, that output stays low for the whole window. For P=9, D=4, T=4, A never rises and B is high 2 cycles per period.
- R5: With D=0, A never rises and B stays high continuously once the delay has passed. With D>P, A stays high continuously and B never rises.
- R6: The period, duty and dead-band inputs are taken only in the cycle where the timer equals the period value, or while the block is disabled. A change made in mid-period has no effect before the next period starts.
- R7: Out A and out B are never high in the same cycle.
- R8: With en low, both outputs are low in that same cycle, the timer and the dead-band counter are cleared, and the inputs are sampled. After en rises, the timer starts at zero and both outputs wait out the dead band. For P=9, D=4, T=3, the first period gives A 1 cycle and B 3 cycles.
- R9: Bit 0 of oe_i gates output A and bit 1 gates output B. A masked output is low, and the other output keeps its timing.
- R10: After reset, both outputs are low and all sampled values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable. Low holds the outputs low and clears the counters |
| period_i | input | CNT_W | Period value P (period is P+1 cycles) |
| duty_i | input | CNT_W | Duty value D (A window is counts below D) |
| dead_i | input | DB_W | Dead-band delay T in clock cycles |
| oe_i | input | 2 | Output enable mask: bit 0 for A, bit 1 for B |
| out_a | output | 1 | Primary PWM output, active-high |
| out_b | output | 1 | Complementary PWM output, active-high |

## Verification
The bench aims at the dead-band edge cases. When the delay equals the window length, a design that compares with the wrong inclusive bound leaks a one-cycle glitch pulse. A design that delays the falling edge as well makes A and B overlap. The duty extremes of zero and above the period are exercised: a design that restarts its delay every period would chop the continuous output into pulses. A duty change is written right after A falls, where a design without buffering would raise A again in the same period. The first period after enable is counted cycle by cycle, which catches a design that lets one output skip the dead band at start-up.

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int CNT_W = 8,
  parameter int DB_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DB_W-1:0]  dead_i,
  input  logic [1:0]       oe_i,
  output logic             out_a,
  output logic             out_b
);

  localparam logic [DB_W-1:0] AGE_MAX = '1;

  logic [CNT_W-1:0] cnt, per_q, duty_q;
  logic [DB_W-1:0]  dead_q, run_q;
  logic             pwm_q;

  wire             at_end = (cnt == per_q);
  wire             pwm    = (cnt < duty_q);
  wire             flip   = pwm ^ pwm_q;
  wire [DB_W-1:0]  age    = flip ? '0 : run_q;
  wire             ready  = (age >= dead_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_q  <= '0;
      duty_q <= '0;
      dead_q <= '0;
      run_q  <= '0;
      pwm_q  <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      per_q  <= period_i;
      duty_q <= duty_i;
      dead_q <= dead_i;
      run_q  <= '0;
      pwm_q  <= 1'b0;
    end else begin
      pwm_q <= pwm;
      run_q <= (age == AGE_MAX) ? age : age + 1'b1;
      if (at_end) begin
        cnt    <= '0;
        per_q  <= period_i;
        duty_q <= duty_i;
        dead_q <= dead_i;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign out_a = en & oe_i[0] &  pwm & ready;
  assign out_b = en & oe_i[1] & ~pwm & ready;

endmodule

// File: rtl/cpwm_deadband_chk.sv
module cpwm_deadband_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       oe_i,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_q,
  input logic             out_a,
  input logic             out_b
);

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!out_a && !out_b));

  // R8
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  // R9
  mask_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_i[0] |-> !out_a);

  // R9
  mask_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_i[1] |-> !out_b);

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == per_q) |=> (cnt == '0));

  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != per_q) |=> (cnt == $past(cnt) + 1'b1));

endmodule

bind cpwm_deadband cpwm_deadband_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .oe_i(oe_i),
  .cnt(cnt), .per_q(per_q), .out_a(out_a), .out_b(out_b)
);

// File: tb/cpwm_deadband_tb.sv
`timescale 1ns/1ps
module cpwm_deadband_tb;
  logic       clk = 0, rst_n = 0, en = 0;
  logic [7:0] period_i = 0, duty_i = 0;
  logic [6:0] dead_i = 0;
  logic [1:0] oe_i = 2'b11;
  logic       out_a, out_b;
  int total = 0, bad = 0;

  cpwm_deadband u_dut (.clk(clk), .rst_n(rst_n), .en(en), .period_i(period_i),
    .duty_i(duty_i), .dead_i(dead_i), .oe_i(oe_i), .out_a(out_a), .out_b(out_b));

  always #5 clk = ~clk;

  // behavioural model: timer, sampled values, and cycles since the level changed
  int m_cnt = 0, m_per = 0, m_duty = 0, m_dead = 0, m_since = 0;
  bit m_prev = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_duty = 0; m_dead = 0; m_since = 0; m_prev = 0;
    end else if (!en) begin
      m_cnt = 0; m_per = period_i; m_duty = duty_i; m_dead = dead_i;
      m_since = 0; m_prev = 0;
    end else begin
      bit lvl;
      lvl = (m_cnt < m_duty);
      m_since = (lvl != m_prev) ? 1 : m_since + 1;
      m_prev = lvl;
      if (m_cnt == m_per) begin
        m_cnt = 0; m_per = period_i; m_duty = duty_i; m_dead = dead_i;
      end else m_cnt++;
    end
  end

  function automatic bit exp_out(bit which_b);
    bit lvl;
    int held;
    lvl  = (m_cnt < m_duty);
    held = (lvl != m_prev) ? 0 : m_since;
    if (!en || !oe_i[which_b]) return 0;
    if ((which_b ? !lvl : lvl) && held >= m_dead) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
    end
  endtask

  task automatic cmp_model();
    chk(out_a == exp_out(0), "R3", "out_a vs model (R1 R6)", out_a, exp_out(0));
    chk(out_b == exp_out(1), "R3", "out_b vs model (R2 R6)", out_b, exp_out(1));
    chk(!(out_a && out_b), "R7", "overlap", 1, 0);
  endtask

  task automatic step();
    @(negedge clk); #1;
    cmp_model();
  endtask

  task automatic restart(int p, int d, int t);
    en = 0; period_i = 8'(p); duty_i = 8'(d); dead_i = 7'(t);
    step();
    chk(!out_a && !out_b, "R8", "outputs while disabled", {out_a, out_b}, 0);
    en = 1; #1;
    cmp_model();
  endtask

  task automatic win(int n, output int ca, output int cb);
    ca = 0; cb = 0;
    for (int i = 0; i < n; i++) begin
      ca += out_a; cb += out_b;
      step();
    end
  endtask

  task automatic settle();
    for (int i = 0; i < 20; i++) step();
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ca, cb;
    void'($urandom(32'd4242));
    #22;
    chk(!out_a && !out_b, "R10", "outputs in reset", {out_a, out_b}, 0);
    rst_n = 1;
    step();
    chk(!out_a && !out_b, "R10", "outputs after reset", {out_a, out_b}, 0);

    // R3 dead band shortens both pulses
    restart(9, 4, 2); settle(); win(30, ca, cb);
    chk(ca == 6, "R3", "A high cycles", ca, 6);
    chk(cb == 12, "R2", "B high cycles", cb, 12);

    // R4 delay equal to window swallows pulse
    restart(9, 4, 4); settle(); win(30, ca, cb);
    chk(ca == 0, "R4", "A high cycles", ca, 0);
    chk(cb == 6, "R4", "B high cycles", cb, 6);

    // R5 duty extremes
    restart(9, 0, 3); settle(); win(30, ca, cb);
    chk(ca == 0, "R5", "A with duty 0", ca, 0);
    chk(cb == 30, "R5", "B with duty 0", cb, 30);
    restart(9, 12, 3); settle(); win(30, ca, cb);
    chk(ca == 30, "R5", "A with duty above period", ca, 30);
    chk(cb == 0, "R5", "B with duty above period", cb, 0);

    // R6 mid-period duty change
    restart(9, 4, 0);
    while (out_a) step();
    duty_i = 8'd8;
    win(6, ca, cb);
    chk(ca == 0, "R6", "A after mid-period write", ca, 0);
    win(8, ca, cb);
    chk(ca == 8, "R6", "A in next period", ca, 8);

    // R8 first period after enable, and disable mid-run
    restart(9, 4, 3); win(10, ca, cb);
    chk(ca == 1, "R8", "A in first period", ca, 1);
    chk(cb == 3, "R8", "B in first period", cb, 3);
    settle();
    en = 0; #1;
    chk(!out_a && !out_b, "R8", "outputs on disable", {out_a, out_b}, 0);

    // R9 output mask
    oe_i = 2'b10; restart(9, 4, 2); settle(); win(30, ca, cb);
    chk(ca == 0 && cb == 12, "R9", "mask A (A,B)", ca * 100 + cb, 12);
    oe_i = 2'b01; restart(9, 4, 2); settle(); win(30, ca, cb);
    chk(ca == 6 && cb == 0, "R9", "mask B (A,B)", ca * 100 + cb, 600);
    oe_i = 2'b11;

    // random phase: R1 R3 R6 against model
    en = 1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) period_i = 8'($urandom_range(15));
      if ($urandom_range(7) == 0) duty_i = 8'($urandom_range(17));
      if ($urandom_range(7) == 0) dead_i = 7'($urandom_range(9));
      if ($urandom_range(31) == 0) oe_i = 2'($urandom_range(3));
      en = ($urandom_range(63) != 0);
      #1; cmp_model();
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule